// File: doc/BRIEF.md
# Power-Management Function Configuration Register Window

This block holds the configuration registers of a power-management function that sits on a PCI-style configuration path. Writes arrive as 32-bit dwords, and byte enables select which lanes are written. Reads return one addressed dword one cycle after the request. Two registers in the space set up I/O windows, and the block sanitises both on every write. A 32-bit register and a control byte place a 64-byte power-management I/O window. Another base register and a control nibble place an SMBus I/O window. The enable and base of each window leave the block as registered decode outputs, which the surrounding I/O routing uses.

The block also keeps the PM1 event status and enable registers. A small side port gives access to them. Event pulses from the platform set status bits, and software clears a bit by writing 1 to it. The block drives a level-sensitive SCI when an enabled source is pending. It also drives a request that arms the external PM timer while the timer event is enabled but not yet pending.

Top module: `pmfn_regwin`

## Requirements
- R1: After reset, the dwords at byte offsets 0x04, 0x40, 0x48, 0x80, 0x90 and 0xd0 read 0x02800000, 0x00000000, 0x00000001, 0x00000000, 0x00000001 and 0x00000000. Both window enables read 0, and SCI is low.
- R2: A read request (`cfg_rd`) puts the addressed dword on `cfg_rdata` at the next clock edge. The value read is the state before any write in the same cycle, and `cfg_rdata` holds that value until the next read. Offsets that are not mapped read zero and ignore writes.
- R3: Bits [15:0] of offset 0x04 (command) are writable per byte lane. Bits [31:16] always read 0x0280, and writes to them have no effect.
- R4: At offset 0x90 the block keeps only bits [15:4] of written data, merged per byte lane. Bits [3:1] and [31:16] read 0, and bit 0 always reads 1.
- R5: A write to offset 0xd0 with byte lane 2 enabled stores only bits [19:16]. Bits [23:20] read 0, and the other three bytes of that dword read 0.
- R6: One cycle after its source register changes, `smb_win_en` equals bit 16 of dword 0xd0 (bit 0 of byte 0xd2), and `smb_win_base` equals offset 0x90 ANDed with 0xfff0.
- R7: One cycle after its source register changes, `pm_win_en` equals bit 0 of offset 0x80, and `pm_win_base` equals offset 0x40 with bits [5:0] cleared (a 64-byte-aligned window). Offset 0x80 stores byte 0 only.
- R8: Offset 0x48 is a fully writable 32-bit register with reset value 0x00000001.
- R9: PM1 status implements bit 0 (timer), bit 5 (global lock), bit 8 (power button) and bit 10 (RTC alarm). The matching event pulse sets each bit. A side-port write with `pm_sel`=0 clears each bit written as 1. A set in the same cycle beats a clear. All other bits read 0.
- R10: A side-port write with `pm_sel`=1 stores the PM1 enable register, keeping only bits 0, 5, 8 and 10.
- R11: `sci` is high in the same cycle that any of the four sources has both its status and its enable bit set. It falls in the cycle that this stops being true.
- R12: `tmr_arm` is high exactly when enable bit 0 is set and status bit 0 is clear.
- R13: A side-port read returns status (`pm_sel`=0) or enable (`pm_sel`=1) on `pm_rdata` at the next edge, and the value holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw | input | 6 | Dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| pm_wr | input | 1 | PM1 side-port write strobe |
| pm_rd | input | 1 | PM1 side-port read strobe |
| pm_sel | input | 1 | 0 selects status, 1 selects enable |
| pm_wdata | input | 16 | PM1 write data |
| pm_rdata | output | 16 | Registered PM1 read data |
| ev_tmr | input | 1 | PM timer event pulse |
| ev_glbl | input | 1 | Global lock event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_rtc | input | 1 | RTC alarm event pulse |
| pm_win_en | output | 1 | PM I/O window enable |
| pm_win_base | output | 32 | PM I/O window base, 64-byte aligned |
| smb_win_en | output | 1 | SMBus I/O window enable |
| smb_win_base | output | 16 | SMBus I/O window base, 16-byte aligned |
| sci | output | 1 | Level-sensitive system control interrupt |
| tmr_arm | output | 1 | Request to arm the PM timer |

## Verification
On every cycle the assertions check the read-back shape of the sanitised registers (fixed status half, forced bit 0 and zero upper bits at 0x90, cleared nibble at 0xd2). They also check that each window output follows its control register with one cycle of lag, and that an SCI rising edge always follows an event pulse or an enable write. In addition they check that a write-one-to-clear takes effect, that a set beats a clear, and that a timer event drops the arm request. Only the bench scenarios can show the actual stored values: partial byte-lane merges at each offset, writes to unmapped offsets being dropped, a read racing a write in the same cycle, and the exact combinations of status and enable that raise or drop SCI.

// File: rtl/pmfn_pkg.sv
package pmfn_pkg;

  // Byte offsets of the mapped configuration dwords
  localparam int OFF_CMD    = 'h04;
  localparam int OFF_PMBASE = 'h40;
  localparam int OFF_MISC   = 'h48;
  localparam int OFF_PMCTL  = 'h80;
  localparam int OFF_SMB    = 'h90;
  localparam int OFF_SMBCTL = 'hd0;

  // Constant upper half of dword 0x04: fast back-to-back, medium select timing
  localparam logic [15:0] PCI_STS_VAL = 16'h0280;
  localparam logic [31:0] MISC_RST    = 32'h0000_0001;

  // PM1 event bit positions (shared by status and enable)
  localparam int PM1_TMR = 0;
  localparam int PM1_GBL = 5;
  localparam int PM1_PWR = 8;
  localparam int PM1_RTC = 10;

  localparam int PM1_IMPL = (1 << PM1_TMR) | (1 << PM1_GBL) |
                            (1 << PM1_PWR) | (1 << PM1_RTC);

endpackage

// File: rtl/pmfn_cfg_regs.sv
module pmfn_cfg_regs
  import pmfn_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic            cfg_rd,
  input  logic [AW-1:0]   cfg_dw,
  input  logic [DW/8-1:0] cfg_be,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic [DW-1:0]   pm_base,
  output logic            pm_en,
  output logic [15:0]     smb_base,
  output logic            smb_en
);

  localparam int NB = DW / 8;

  localparam logic [AW-1:0] IX_CMD    = AW'(OFF_CMD / 4);
  localparam logic [AW-1:0] IX_PMBASE = AW'(OFF_PMBASE / 4);
  localparam logic [AW-1:0] IX_MISC   = AW'(OFF_MISC / 4);
  localparam logic [AW-1:0] IX_PMCTL  = AW'(OFF_PMCTL / 4);
  localparam logic [AW-1:0] IX_SMB    = AW'(OFF_SMB / 4);
  localparam logic [AW-1:0] IX_SMBCTL = AW'(OFF_SMBCTL / 4);

  logic [15:0]   cmd_q;
  logic [DW-1:0] pmbase_q;
  logic [DW-1:0] misc_q;
  logic [7:0]    pmctl_q;
  logic [11:0]   smb_q;      // only address bits [15:4] are stored
  logic [3:0]    smbctl_q;   // low nibble of byte 0xd2

  logic [15:0]   cmd_nx;
  logic [11:0]   smb_nx;
  logic [DW-1:0] rd_word;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [NB-1:0] be);
    logic [DW-1:0] r;
    r = old_v;
    for (int i = 0; i < NB; i++) begin
      if (be[i]) r[i*8 +: 8] = new_v[i*8 +: 8];
    end
    return r;
  endfunction

  always_comb begin
    cmd_nx[15:8] = cfg_be[1] ? cfg_wdata[15:8] : cmd_q[15:8];
    cmd_nx[7:0]  = cfg_be[0] ? cfg_wdata[7:0]  : cmd_q[7:0];
    smb_nx[11:4] = cfg_be[1] ? cfg_wdata[15:8] : smb_q[11:4];
    smb_nx[3:0]  = cfg_be[0] ? cfg_wdata[7:4]  : smb_q[3:0];
  end

  always_comb begin
    case (cfg_dw)
      IX_CMD:    rd_word = {PCI_STS_VAL, cmd_q};
      IX_PMBASE: rd_word = pmbase_q;
      IX_MISC:   rd_word = misc_q;
      IX_PMCTL:  rd_word = {24'h0, pmctl_q};
      IX_SMB:    rd_word = {16'h0, smb_q, 4'h1};
      IX_SMBCTL: rd_word = {8'h0, 4'h0, smbctl_q, 16'h0};
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      pmbase_q  <= '0;
      misc_q    <= MISC_RST;
      pmctl_q   <= '0;
      smb_q     <= '0;
      smbctl_q  <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr) begin
        case (cfg_dw)
          IX_CMD:    cmd_q    <= cmd_nx;
          IX_PMBASE: pmbase_q <= lane_merge(pmbase_q, cfg_wdata, cfg_be);
          IX_MISC:   misc_q   <= lane_merge(misc_q, cfg_wdata, cfg_be);
          IX_PMCTL:  if (cfg_be[0]) pmctl_q <= cfg_wdata[7:0];
          IX_SMB:    smb_q    <= smb_nx;
          IX_SMBCTL: if (cfg_be[2]) smbctl_q <= cfg_wdata[19:16];
          default:   ;
        endcase
      end
      if (cfg_rd) cfg_rdata <= rd_word;
    end
  end

  assign pm_base  = pmbase_q;
  assign pm_en    = pmctl_q[0];
  assign smb_base = {smb_q, 4'h0};
  assign smb_en   = smbctl_q[0];

  // R3
  sts_const_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_dw == IX_CMD) |=> (cfg_rdata[31:16] == PCI_STS_VAL));

  // R4
  smb_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_dw == IX_SMB) |=>
      (cfg_rdata[0] && cfg_rdata[3:1] == 3'b000 && cfg_rdata[31:16] == 16'h0));

  // R5
  smbctl_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd && cfg_dw == IX_SMBCTL) |=> (cfg_rdata[31:20] == 12'h0 && cfg_rdata[15:0] == 16'h0));

endmodule

// File: rtl/pmfn_io_win.sv
module pmfn_io_win #(
  parameter int AW    = 16,
  parameter int ALIGN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_in,
  input  logic [AW-1:0] base_in,
  output logic          win_en,
  output logic [AW-1:0] win_base
);

  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en   <= 1'b0;
      win_base <= '0;
    end else begin
      win_en   <= en_in;
      win_base <= base_in & ~LOW_MASK;
    end
  end

  // R6 R7
  win_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (win_en == $past(en_in)));

  // R6 R7
  win_align_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((win_base & LOW_MASK) == '0 &&
                     (win_base | LOW_MASK) == ($past(base_in) | LOW_MASK)));

endmodule

// File: rtl/pmfn_pm1.sv
module pmfn_pm1
  import pmfn_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] evt_set,
  input  logic          pm_wr,
  input  logic          pm_rd,
  input  logic          pm_sel,
  input  logic [PW-1:0] pm_wdata,
  output logic [PW-1:0] pm_rdata,
  output logic          sci,
  output logic          tmr_arm
);

  localparam logic [PW-1:0] IMPL = PW'(PM1_IMPL);

  logic [PW-1:0] sts_q;
  logic [PW-1:0] en_q;
  logic [PW-1:0] clr;

  assign clr = (pm_wr && !pm_sel) ? pm_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q    <= '0;
      en_q     <= '0;
      pm_rdata <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr) | evt_set) & IMPL;
      if (pm_wr && pm_sel) en_q <= pm_wdata & IMPL;
      if (pm_rd) pm_rdata <= pm_sel ? en_q : sts_q;
    end
  end

  assign sci     = |(sts_q & en_q & IMPL);
  assign tmr_arm = en_q[PM1_TMR] & ~sts_q[PM1_TMR];

  // R11
  sci_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sci) |-> ($past(|evt_set) || $past(pm_wr && pm_sel)));

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_wr && !pm_sel && pm_wdata[PM1_PWR] && !evt_set[PM1_PWR]) |=> !sts_q[PM1_PWR]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((sts_q & $past(evt_set & IMPL)) == $past(evt_set & IMPL)));

  // R12
  tmr_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt_set[PM1_TMR] |=> !tmr_arm);

endmodule

// File: rtl/pmfn_regwin.sv
module pmfn_regwin
  import pmfn_pkg::*;
#(
  parameter int CFG_AW        = 6,
  parameter int CFG_DW        = 32,
  parameter int PM1_W         = 16,
  parameter int SMB_AW        = 16,
  parameter int PM_WIN_BYTES  = 64,
  parameter int SMB_WIN_BYTES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [CFG_AW-1:0]   cfg_dw,
  input  logic [CFG_DW/8-1:0] cfg_be,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic                pm_wr,
  input  logic                pm_rd,
  input  logic                pm_sel,
  input  logic [PM1_W-1:0]    pm_wdata,
  output logic [PM1_W-1:0]    pm_rdata,
  input  logic                ev_tmr,
  input  logic                ev_glbl,
  input  logic                ev_pwrbtn,
  input  logic                ev_rtc,
  output logic                pm_win_en,
  output logic [CFG_DW-1:0]   pm_win_base,
  output logic                smb_win_en,
  output logic [SMB_AW-1:0]   smb_win_base,
  output logic                sci,
  output logic                tmr_arm
);

  localparam int PM_ALIGN  = $clog2(PM_WIN_BYTES);
  localparam int SMB_ALIGN = $clog2(SMB_WIN_BYTES);

  logic [CFG_DW-1:0] pm_base;
  logic              pm_en;
  logic [15:0]       smb_base;
  logic              smb_en;
  logic [PM1_W-1:0]  evt_vec;

  pmfn_cfg_regs #(.AW(CFG_AW), .DW(CFG_DW)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .pm_en(pm_en),
    .smb_base(smb_base), .smb_en(smb_en)
  );

  pmfn_io_win #(.AW(CFG_DW), .ALIGN(PM_ALIGN)) u_pm_win (
    .clk(clk), .rst(rst), .en_in(pm_en), .base_in(pm_base),
    .win_en(pm_win_en), .win_base(pm_win_base)
  );

  pmfn_io_win #(.AW(SMB_AW), .ALIGN(SMB_ALIGN)) u_smb_win (
    .clk(clk), .rst(rst), .en_in(smb_en), .base_in(SMB_AW'(smb_base)),
    .win_en(smb_win_en), .win_base(smb_win_base)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[PM1_TMR] = ev_tmr;
    evt_vec[PM1_GBL] = ev_glbl;
    evt_vec[PM1_PWR] = ev_pwrbtn;
    evt_vec[PM1_RTC] = ev_rtc;
  end

  pmfn_pm1 #(.PW(PM1_W)) u_pm1 (
    .clk(clk), .rst(rst), .evt_set(evt_vec),
    .pm_wr(pm_wr), .pm_rd(pm_rd), .pm_sel(pm_sel), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata), .sci(sci), .tmr_arm(tmr_arm)
  );

endmodule

// File: tb/pmfn_regwin_tb_top.sv
module pmfn_regwin_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0;
  logic [5:0]  cfg_dw = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        pm_wr = 0, pm_rd = 0, pm_sel = 0;
  logic [15:0] pm_wdata = 0;
  logic [15:0] pm_rdata;
  logic        ev_tmr = 0, ev_glbl = 0, ev_pwrbtn = 0, ev_rtc = 0;
  logic        pm_win_en, smb_win_en, sci, tmr_arm;
  logic [31:0] pm_win_base;
  logic [15:0] smb_win_base;

  int n_chk = 0;
  int n_err = 0;
  bit live  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pmfn_regwin dut_i (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_wr(pm_wr), .pm_rd(pm_rd), .pm_sel(pm_sel), .pm_wdata(pm_wdata),
    .pm_rdata(pm_rdata),
    .ev_tmr(ev_tmr), .ev_glbl(ev_glbl), .ev_pwrbtn(ev_pwrbtn), .ev_rtc(ev_rtc),
    .pm_win_en(pm_win_en), .pm_win_base(pm_win_base),
    .smb_win_en(smb_win_en), .smb_win_base(smb_win_base),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  // ---------------- reference model (byte array view of config space) -----
  logic [7:0]  m_cfg [256];
  logic [15:0] m_sts, m_en, m_pmr, m_swb;
  logic [31:0] m_rd, m_pwb;
  logic        m_pwe, m_swe;

  function automatic logic [31:0] m_word(input int dw);
    return {m_cfg[dw*4+3], m_cfg[dw*4+2], m_cfg[dw*4+1], m_cfg[dw*4]};
  endfunction

  function automatic bit m_wr_ok(input int a);
    return (a == 'h04) || (a == 'h05) || (a >= 'h40 && a <= 'h43) ||
           (a >= 'h48 && a <= 'h4b) || (a == 'h80) ||
           (a >= 'h90 && a <= 'h93) || (a == 'hd2);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_cfg[i]) m_cfg[i] = 8'h00;
      m_cfg['h06] = 8'h80;  m_cfg['h07] = 8'h02;
      m_cfg['h48] = 8'h01;  m_cfg['h90] = 8'h01;
      m_sts = 0; m_en = 0; m_pmr = 0; m_rd = 0;
      m_pwe = 0; m_pwb = 0; m_swe = 0; m_swb = 0;
    end else begin
      // registered window outputs follow the pre-edge register contents
      m_pwe = m_cfg['h80][0];
      m_pwb = m_word('h40 / 4) & ~32'h3f;
      m_swe = m_cfg['hd2][0];
      m_swb = {m_cfg['h91], m_cfg['h90]} & 16'hfff0;
      if (cfg_rd) m_rd = m_word(int'(cfg_dw));
      if (pm_rd) m_pmr = pm_sel ? m_en : m_sts;
      if (cfg_wr) begin
        for (int b = 0; b < 4; b++) begin
          if (cfg_be[b] && m_wr_ok(int'(cfg_dw) * 4 + b))
            m_cfg[int'(cfg_dw) * 4 + b] = cfg_wdata[b*8 +: 8];
        end
        m_cfg['h90] = (m_cfg['h90] & 8'hf0) | 8'h01;
        m_cfg['h92] = 8'h00;
        m_cfg['h93] = 8'h00;
        m_cfg['hd2] = m_cfg['hd2] & 8'h0f;
      end
      if (pm_wr && !pm_sel) m_sts = m_sts & ~pm_wdata;
      if (pm_wr && pm_sel)  m_en  = pm_wdata & 16'h0521;
      if (ev_tmr)    m_sts[0]  = 1'b1;
      if (ev_glbl)   m_sts[5]  = 1'b1;
      if (ev_pwrbtn) m_sts[8]  = 1'b1;
      if (ev_rtc)    m_sts[10] = 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (live && !rst && !done) begin
      chk("R2 cfg_rdata", cfg_rdata, m_rd);
      chk("R13 pm_rdata", {16'h0, pm_rdata}, {16'h0, m_pmr});
      chk("R7 pm_win_en", {31'h0, pm_win_en}, {31'h0, m_pwe});
      chk("R7 pm_win_base", pm_win_base, m_pwb);
      chk("R6 smb_win_en", {31'h0, smb_win_en}, {31'h0, m_swe});
      chk("R6 smb_win_base", {16'h0, smb_win_base}, {16'h0, m_swb});
      chk("R11 sci", {31'h0, sci}, {31'h0, |(m_sts & m_en)});
      chk("R12 tmr_arm", {31'h0, tmr_arm}, {31'h0, m_en[0] & ~m_sts[0]});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic cfg_write(input int dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_dw = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic cfg_expect(input int dw, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1; cfg_dw = 6'(dw);
    @(negedge clk);
    cfg_rd = 0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic pm_write(input logic sel, input logic [15:0] d);
    @(negedge clk);
    pm_wr = 1; pm_sel = sel; pm_wdata = d;
    @(negedge clk);
    pm_wr = 0;
  endtask

  task automatic pm_expect(input logic sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    pm_rd = 1; pm_sel = sel;
    @(negedge clk);
    pm_rd = 0;
    chk(tag, {16'h0, pm_rdata}, {16'h0, exp});
  endtask

  task automatic pulse(input logic [3:0] ev);  // {rtc, pwrbtn, glbl, tmr}
    @(negedge clk);
    {ev_rtc, ev_pwrbtn, ev_glbl, ev_tmr} = ev;
    @(negedge clk);
    {ev_rtc, ev_pwrbtn, ev_glbl, ev_tmr} = 4'h0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    live = 1;

    // R1 reset values
    cfg_expect(1,  32'h0280_0000, "R1 off04");
    cfg_expect(16, 32'h0000_0000, "R1 off40");
    cfg_expect(18, 32'h0000_0001, "R1 off48");
    cfg_expect(32, 32'h0000_0000, "R1 off80");
    cfg_expect(36, 32'h0000_0001, "R1 off90");
    cfg_expect(52, 32'h0000_0000, "R1 offd0");
    chk("R1 windows off", {30'h0, pm_win_en, smb_win_en}, 32'h0);
    chk("R1 sci low", {31'h0, sci}, 32'h0);

    // R3 command writable, status fixed
    cfg_write(1, 4'hf, 32'hffff_1234);
    cfg_expect(1, 32'h0280_1234, "R3 cmd/sts");
    // R8 misc register partial write
    cfg_write(18, 4'h3, 32'haaaa_5678);
    cfg_expect(18, 32'h0000_5678, "R8 misc");
    // R4 SMBus base sanitising
    cfg_write(36, 4'hf, 32'hdead_beef);
    cfg_expect(36, 32'h0000_bee1, "R4 smb full");
    cfg_write(36, 4'h1, 32'h0000_0034);
    cfg_expect(36, 32'h0000_be31, "R4 smb lane0");
    cfg_write(36, 4'hc, 32'hffff_0000);
    cfg_expect(36, 32'h0000_be31, "R4 smb upper");
    // R5 control nibble
    cfg_write(52, 4'h4, 32'h00ff_0000);
    cfg_expect(52, 32'h000f_0000, "R5 d2 nibble");
    cfg_write(52, 4'hb, 32'hffff_ffff);
    cfg_expect(52, 32'h000f_0000, "R5 other lanes");
    chk("R6 smb window en", {31'h0, smb_win_en}, 32'h1);
    chk("R6 smb window base", {16'h0, smb_win_base}, 32'h0000_be30);
    // R2 unmapped offsets
    cfg_write(0, 4'hf, 32'hffff_ffff);
    cfg_expect(0, 32'h0, "R2 unmapped 00");
    cfg_write(63, 4'hf, 32'hffff_ffff);
    cfg_expect(63, 32'h0, "R2 unmapped fc");
    // R7 PM window
    cfg_write(16, 4'hf, 32'h1234_5678);
    cfg_write(32, 4'hf, 32'hffff_ff01);
    cfg_expect(32, 32'h0000_0001, "R7 ctl byte");
    chk("R7 pm window en", {31'h0, pm_win_en}, 32'h1);
    chk("R7 pm window base", pm_win_base, 32'h1234_5640);

    // R10 enable masking
    pm_write(1, 16'hffff);
    pm_expect(1, 16'h0521, "R10 enable mask");
    chk("R12 arm while idle", {31'h0, tmr_arm}, 32'h1);
    // R9 / R11 power button
    pulse(4'b0100);
    chk("R11 sci on pwrbtn", {31'h0, sci}, 32'h1);
    pm_expect(0, 16'h0100, "R9 pwrbtn status");
    pm_write(0, 16'h0100);
    chk("R11 sci cleared", {31'h0, sci}, 32'h0);
    // R12 timer event drops arm
    pulse(4'b0001);
    chk("R12 arm dropped", {31'h0, tmr_arm}, 32'h0);
    // R9 set beats clear in the same cycle
    @(negedge clk);
    pm_wr = 1; pm_sel = 0; pm_wdata = 16'h0001; ev_tmr = 1;
    @(negedge clk);
    pm_wr = 0; ev_tmr = 0;
    pm_expect(0, 16'h0001, "R9 set wins");
    pulse(4'b1111);
    pm_expect(0, 16'h0521, "R9 all sources");
    pm_write(0, 16'hffff);
    pm_expect(0, 16'h0000, "R9 clear all");
    // R11 disabled sources do not raise SCI
    pm_write(1, 16'h0000);
    pulse(4'b1010);
    chk("R11 masked", {31'h0, sci}, 32'h0);
    pm_write(1, 16'h0400);
    chk("R11 enable raises", {31'h0, sci}, 32'h1);
    pm_write(0, 16'hffff);

    // random mixed traffic, compared every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      cfg_wr = ($urandom % 3) == 0;
      cfg_rd = ($urandom % 2) == 0;
      case ($urandom % 8)
        0: cfg_dw = 6'd1;
        1: cfg_dw = 6'd16;
        2: cfg_dw = 6'd18;
        3: cfg_dw = 6'd32;
        4: cfg_dw = 6'd36;
        5: cfg_dw = 6'd52;
        default: cfg_dw = 6'($urandom % 64);
      endcase
      cfg_be    = 4'($urandom);
      cfg_wdata = $urandom;
      pm_wr     = ($urandom % 6) == 0;
      pm_rd     = ($urandom % 2) == 0;
      pm_sel    = 1'($urandom);
      pm_wdata  = 16'($urandom);
      ev_tmr    = ($urandom % 8) == 0;
      ev_glbl   = ($urandom % 8) == 0;
      ev_pwrbtn = ($urandom % 8) == 0;
      ev_rtc    = ($urandom % 8) == 0;
    end
    @(negedge clk);
    {cfg_wr, cfg_rd, pm_wr, pm_rd, ev_tmr, ev_glbl, ev_pwrbtn, ev_rtc} = '0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule